// File: doc/BRIEF.md
# Four-Rail Power-Good Sequencer

This block switches on four downstream supplies in a fixed order by releasing four power-good flags one after another: A first, then B, then C, then D. It acts only while the input supply is inside its allowed window. The window is judged from two digital comparator flags. One reports that the supply is above its undervoltage threshold. The other reports that it is above its overvoltage threshold.

The sequence starts when the window is entered. A loadable down-counter then times a programmable start-up wait, after which flag A goes active. Each following flag goes active a programmable gap after the previous one. A gap is 255 full periods of a prescaled tick, and each period is two half-periods of programmable length. The start-up word and the three gap words are captured when a sequence starts.

Any excursion out of the window drops every flag and clears all timing. When the supply comes back into the window, a fresh sequence begins. A build-time parameter selects whether an active flag drives 1 or 0. A 3-bit stage code reports how far the sequence has progressed.

Top module: `pgood_sequencer`

## Requirements
- R1: While reset is high and after it is released, all four flags are inactive and `stage` reads 0. This holds until an in-window condition has been seen.
- R2: The in-window condition is `uv_above_raw`=1 with `ov_above_raw`=0. Let N be the value of `start_delay`. When the in-window condition is applied and held, flag A goes active after the (N+4)-th rising edge following its application. Up to that edge it stays inactive and `stage` reads 1.
- R3: Flag B goes active exactly 510*(`gap_ab`+1) clock cycles after flag A. Flag C goes active 510*(`gap_bc`+1) cycles after B. Flag D goes active 510*(`gap_cd`+1) cycles after C. Each of the three gaps depends only on its own word.
- R4: The flags form a thermometer: B is never active without A, C never without B, and D never without C. In `pg_out`, bit 0 is A, bit 1 is B, bit 2 is C and bit 3 is D.
- R5: The window is left when `uv_above_raw` goes to 0 or `ov_above_raw` goes to 1, even for a single cycle. After the third rising edge following that change, all four flags are inactive and `stage` reads 0, whatever stage was reached.
- R6: When the window is re-entered after an excursion, a new sequence starts from the full start-up wait. Flag A again follows after the (N+4)-th edge. This also applies when the excursion happened during the start-up wait.
- R7: The start-up and gap words are captured on the edge where `stage` goes from 0 to 1. Changes made to them later have no effect until the next sequence starts.
- R8: With ACTIVE_HIGH=1 an active flag drives 1 and an inactive flag drives 0. With ACTIVE_HIGH=0 both levels are inverted.
- R9: `stage` encodes progress: 0 = idle or fault, 1 = start-up wait, 2 = A active, 3 = A and B active, 4 = A to C active, 5 = all four active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_above_raw | input | 1 | Asynchronous flag: 1 when the supply is above the undervoltage threshold |
| ov_above_raw | input | 1 | Asynchronous flag: 1 when the supply is above the overvoltage threshold |
| start_delay | input | START_W | Start-up wait N, in clock cycles |
| gap_ab | input | HALF_W | Half-period length minus one, used for the A-to-B gap |
| gap_bc | input | HALF_W | Half-period length minus one, used for the B-to-C gap |
| gap_cd | input | HALF_W | Half-period length minus one, used for the C-to-D gap |
| pg_out | output | 4 | Power-good flags, bit 0 = A to bit 3 = D, polarity set by ACTIVE_HIGH |
| stage | output | 3 | Sequence stage code |

## Verification
The hardest situation to reach is an excursion lasting a single cycle that lands partway through a gap or partway through the start-up wait. Such an excursion must still clear the partly counted timers. The bench drives a one-cycle undervoltage dip while A and B are active, and an overvoltage pulse during the start-up wait. It then times the restarted sequence edge by edge to confirm that the full wait is counted again. A further test changes the delay words in the middle of a sequence, to show that the captured copy is the one in use. A second, inverted-polarity instance runs in parallel, and every flag check is applied to it as well.

// File: rtl/pgood_pkg.sv
package pgood_pkg;
  localparam int RAILS = 4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_A    = 3'd2,
    ST_B    = 3'd3,
    ST_C    = 3'd4,
    ST_ALL  = 3'd5
  } seq_state_e;
endpackage

// File: rtl/pgood_sync.sv
module pgood_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= '0;
        else     chain[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= '0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pgood_start_timer.sv
module pgood_start_timer #(
  parameter int START_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               load,
  input  logic [START_W-1:0] load_val,
  input  logic               run,
  output logic               zero
);
  logic [START_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)               cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pgood_gap_timer.sv
module pgood_gap_timer #(
  parameter int HALF_W  = 8,
  parameter int PERIODS = 255
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [HALF_W-1:0] half_len,
  output logic              done
);
  localparam int CNT_W = $clog2(PERIODS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIODS - 1);

  logic [HALF_W-1:0] pre_q;
  logic              phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              half_tick;

  // one half-period of the modelled oscillator ends here
  assign half_tick = (pre_q == half_len);
  assign done      = half_tick && phase_q && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre_q   <= '0;
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else if (half_tick) begin
      pre_q   <= '0;
      phase_q <= ~phase_q;
      if (phase_q) cnt_q <= cnt_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/pgood_sequencer.sv
module pgood_sequencer
  import pgood_pkg::*;
#(
  parameter bit ACTIVE_HIGH = 1'b1,
  parameter int START_W     = 16,
  parameter int HALF_W      = 8,
  parameter int PERIODS     = 255,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               uv_above_raw,
  input  logic               ov_above_raw,
  input  logic [START_W-1:0] start_delay,
  input  logic [HALF_W-1:0]  gap_ab,
  input  logic [HALF_W-1:0]  gap_bc,
  input  logic [HALF_W-1:0]  gap_cd,
  output logic [RAILS-1:0]   pg_out,
  output logic [2:0]         stage
);
  localparam int GAPS = RAILS - 1;

  logic [1:0]        flags_s;
  logic              in_window;
  seq_state_e        state_q, state_d;
  logic              start_load, start_zero;
  logic              gap_done, gap_clr, in_gap;
  logic [HALF_W-1:0] gap_sel;
  logic [HALF_W-1:0] gap_q [GAPS];
  logic [RAILS-1:0]  act_d, act_q;
  logic [2:0]        st_d_bits;

  pgood_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({uv_above_raw, ov_above_raw}),
    .q   (flags_s)
  );

  assign in_window = flags_s[1] & ~flags_s[0];

  always_comb begin
    state_d    = state_q;
    start_load = 1'b0;
    if (!in_window) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d    = ST_WAIT;
          start_load = 1'b1;
        end
        ST_WAIT: if (start_zero) state_d = ST_A;
        ST_A:    if (gap_done)   state_d = ST_B;
        ST_B:    if (gap_done)   state_d = ST_C;
        ST_C:    if (gap_done)   state_d = ST_ALL;
        default: state_d = state_q;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_B:    gap_sel = gap_q[1];
      ST_C:    gap_sel = gap_q[2];
      default: gap_sel = gap_q[0];
    endcase
  end

  assign in_gap  = (state_q == ST_A) || (state_q == ST_B) || (state_q == ST_C);
  assign gap_clr = !in_window || !in_gap || gap_done;

  pgood_start_timer #(.START_W(START_W)) u_start (
    .clk      (clk),
    .rst      (rst),
    .clr      (!in_window),
    .load     (start_load),
    .load_val (start_delay),
    .run      (state_q == ST_WAIT),
    .zero     (start_zero)
  );

  pgood_gap_timer #(.HALF_W(HALF_W), .PERIODS(PERIODS)) u_gap (
    .clk      (clk),
    .rst      (rst),
    .clr      (gap_clr),
    .half_len (gap_sel),
    .done     (gap_done)
  );

  assign st_d_bits = state_d;
  for (genvar i = 0; i < RAILS; i++) begin : g_rail
    assign act_d[i] = (st_d_bits >= 3'(2 + i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      act_q   <= '0;
    end else begin
      state_q <= state_d;
      act_q   <= act_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < GAPS; i++) gap_q[i] <= '0;
    end else if (start_load) begin
      gap_q[0] <= gap_ab;
      gap_q[1] <= gap_bc;
      gap_q[2] <= gap_cd;
    end
  end

  if (ACTIVE_HIGH) begin : g_pol_high
    assign pg_out = act_q;
  end else begin : g_pol_low
    assign pg_out = ~act_q;
  end

  assign stage = state_q;
endmodule

// File: rtl/pgood_sequencer_chk.sv
module pgood_sequencer_chk #(
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic [3:0] pg,
  input logic [2:0] stage,
  input logic       win
);
  logic [3:0] act;
  assign act = ACTIVE_HIGH ? pg : ~pg;

  // R4: thermometer order of the active flags
  assert_thermo_order_R4: assert property (@(posedge clk) disable iff (rst)
    (act[3:1] & ~act[2:0]) == 3'b000);

  // R5: leaving the window clears the flags and the stage on the next edge
  assert_fault_clear_R5: assert property (@(posedge clk) disable iff (rst)
    !win |=> (act == 4'b0000 && stage == 3'd0));

  // R6: re-entering the window from idle starts the wait
  assert_start_fresh_R6: assert property (@(posedge clk) disable iff (rst)
    (win && stage == 3'd0) |=> stage == 3'd1);

  // R2: flag A only rises out of the start-up wait
  assert_a_after_wait_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(act[0]) |-> $past(stage) == 3'd1);

  // R3: flag B only rises while A is already held
  assert_b_after_a_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(act[1]) |-> ($past(stage) == 3'd2 && $past(act[0])));

  // R9: only defined stage codes appear
  assert_stage_code_R9: assert property (@(posedge clk) disable iff (rst)
    stage <= 3'd5);
endmodule

bind pgood_sequencer pgood_sequencer_chk #(.ACTIVE_HIGH(ACTIVE_HIGH)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .pg    (pg_out),
  .stage (stage),
  .win   (in_window)
);

// File: tb/pgood_sequencer_test.sv
`timescale 1ns/100ps
module pgood_sequencer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        uv = 1'b0;
  logic        ov = 1'b0;
  logic [15:0] start_delay = '0;
  logic [7:0]  gab = '0, gbc = '0, gcd = '0;
  logic [3:0]  pg, pg_low;
  logic [2:0]  stage, stage_low;
  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pgood_sequencer #(.ACTIVE_HIGH(1'b1)) uut (
    .clk(clk), .rst(rst), .uv_above_raw(uv), .ov_above_raw(ov),
    .start_delay(start_delay), .gap_ab(gab), .gap_bc(gbc), .gap_cd(gcd),
    .pg_out(pg), .stage(stage));

  pgood_sequencer #(.ACTIVE_HIGH(1'b0)) uut_low (
    .clk(clk), .rst(rst), .uv_above_raw(uv), .ov_above_raw(ov),
    .start_delay(start_delay), .gap_ab(gab), .gap_bc(gbc), .gap_cd(gcd),
    .pg_out(pg_low), .stage(stage_low));

  // scenario vectors: {start N, gap_ab, gap_bc, gap_cd}
  localparam logic [31:0] VEC [4] = '{
    {8'd0, 8'd0, 8'd0, 8'd0},
    {8'd3, 8'd1, 8'd0, 8'd2},
    {8'd7, 8'd2, 8'd1, 8'd0},
    {8'd1, 8'd0, 8'd3, 8'd1}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // flags in active-level terms, stage code; inverted instance checked too (R8)
  task automatic check_pg(input string req, input logic [3:0] exp_act, input logic [2:0] exp_st);
    check({req, " flags"}, {4'h0, pg}, {4'h0, exp_act});
    check({req, " stage"}, {5'h0, stage}, {5'h0, exp_st});
    check({req, " R8 low-polarity flags"}, {4'h0, pg_low}, {4'h0, ~exp_act});
  endtask

  task automatic go_idle();
    uv = 1'b0; ov = 1'b0;
    step(4);
    check_pg("R5 idle before sequence", 4'b0000, 3'd0);
  endtask

  task automatic run_seq(input int n, input int a, input int b, input int c);
    start_delay = 16'(n); gab = 8'(a); gbc = 8'(b); gcd = 8'(c);
    uv = 1'b1;
    step(n + 3);
    check_pg("R2 wait before A", 4'b0000, 3'd1);
    step(1);
    check_pg("R2 A active", 4'b0001, 3'd2);
    step(510 * (a + 1) - 1);
    check_pg("R3 B not yet", 4'b0001, 3'd2);
    step(1);
    check_pg("R3 B active", 4'b0011, 3'd3);
    step(510 * (b + 1) - 1);
    check_pg("R3 C not yet", 4'b0011, 3'd3);
    step(1);
    check_pg("R3 C active", 4'b0111, 3'd4);
    step(510 * (c + 1) - 1);
    check_pg("R3 D not yet", 4'b0111, 3'd4);
    step(1);
    check_pg("R9 all active", 4'b1111, 3'd5);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state, with the window present during reset
    uv = 1'b1;
    step(3);
    check_pg("R1 in reset", 4'b0000, 3'd0);
    uv = 1'b0;
    rst = 1'b0;
    step(5);
    check_pg("R1 after reset", 4'b0000, 3'd0);

    // table walk: R2, R3, R4, R9
    for (int i = 0; i < 4; i++) begin
      go_idle();
      run_seq(int'(VEC[i][31:24]), int'(VEC[i][23:16]), int'(VEC[i][15:8]), int'(VEC[i][7:0]));
    end

    // R5: overvoltage after full sequence
    ov = 1'b1;
    step(2);
    check_pg("R5 before fault edge", 4'b1111, 3'd5);
    step(1);
    check_pg("R5 OV clears all", 4'b0000, 3'd0);

    // R5/R6: one-cycle UV dip while B active, then fresh start
    go_idle();
    start_delay = 16'd4; gab = 8'd0; gbc = 8'd0; gcd = 8'd0;
    uv = 1'b1;
    step(8);
    step(510);
    check_pg("R3 B active before dip", 4'b0011, 3'd3);
    uv = 1'b0;
    step(1);
    uv = 1'b1;
    step(1);
    check_pg("R5 dip not yet seen", 4'b0011, 3'd3);
    step(1);
    check_pg("R5 one-cycle dip clears", 4'b0000, 3'd0);
    step(1);
    check_pg("R6 restart wait", 4'b0000, 3'd1);
    step(4);
    check_pg("R6 full wait again", 4'b0000, 3'd1);
    step(1);
    check_pg("R6 A after restart", 4'b0001, 3'd2);

    // R6: OV pulse during the start-up wait restarts the full wait
    go_idle();
    start_delay = 16'd6;
    uv = 1'b1;
    step(6);
    ov = 1'b1;
    step(1);
    ov = 1'b0;
    step(2);
    check_pg("R6 fault in wait clears", 4'b0000, 3'd0);
    step(1);
    check_pg("R6 wait restarted", 4'b0000, 3'd1);
    step(6);
    check_pg("R6 no early A", 4'b0000, 3'd1);
    step(1);
    check_pg("R6 A after full wait", 4'b0001, 3'd2);

    // R7: words changed after capture are ignored
    go_idle();
    start_delay = 16'd2; gab = 8'd0; gbc = 8'd0; gcd = 8'd0;
    uv = 1'b1;
    step(3);
    start_delay = 16'd9; gab = 8'd3;
    step(2);
    check_pg("R7 start word captured", 4'b0000, 3'd1);
    step(1);
    check_pg("R7 A uses old start word", 4'b0001, 3'd2);
    gbc = 8'd3;
    step(509);
    check_pg("R7 B not yet", 4'b0001, 3'd2);
    step(1);
    check_pg("R7 B uses old gap word", 4'b0011, 3'd3);
    step(510);
    check_pg("R7 C uses old gap word", 4'b0111, 3'd4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule